// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block turns three Hall position-sensor levels from a three-phase brushless DC motor into six gate commands for the bridge: three high-side commands and three low-side commands, one of each per phase. Motors place their sensors at one of four electrical spacings. A two-bit select picks the spacing so that a single block serves all four. A direction input reverses rotation. A brake input shorts the windings through the low-side switches. An enable input switches the bridge off.

All inputs are asynchronous to the system clock and pass through a synchronizer. The decode is combinational and the gate commands are registered, so they are active-high and glitch-free for the external drivers. Any sensor code that the selected spacing cannot produce switches the whole bridge off.

Top module: `hall_commutator`

## Requirements
- R1: `spacing_i` selects the sensor table: 00 = 60°, 10 = 120°, 01 = 240°, 11 = 300°. With `hall_i[0]` as sensor 1, the 60° table lists steps 0..5 as codes 000, 001, 011, 111, 110, 100. The 120° table lists them as 001, 011, 010, 110, 100, 101. The 240° and 300° tables first reverse the sensor bit order to {hall_i[0],hall_i[1],hall_i[2]} and then apply the 120° and 60° tables respectively.
- R2: A sensor code that is absent from the selected table drives all six outputs low (brake inactive).
- R3: With `dir_i` = 0, step k drives high-side phase k/2 (integer division) and low-side phase (k/2 + 1 + k mod 2) mod 3. Bit 0 of `hi_o` and `lo_o` is phase A, bit 1 is phase B and bit 2 is phase C.
- R4: With `dir_i` = 1, the block outputs the pair of step (k + 3) mod 6 in place of step k, which reverses rotation.
- R5: When `brake_i` is high, `hi_o` = 000 and `lo_o` = 111, whatever the values of enable, direction, spacing and sensors.
- R6: When `enable_i` is low and `brake_i` is low, all six outputs are low.
- R7: During commutation, either no output is on, or exactly one high-side output and exactly one low-side output are on, on different phases.
- R8: An input change reaches the outputs on the third rising clock edge after it is applied (two synchronizer stages plus the output register). While `rst_ni` is low, all outputs are low.
- R9: A high-side output and the low-side output of the same phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Hall sensor levels, bit 0 = sensor 1 |
| spacing_i | input | 2 | Sensor spacing select |
| dir_i | input | 1 | Rotation direction, 1 = reverse |
| enable_i | input | 1 | Bridge enable, active high |
| brake_i | input | 1 | Brake request, active high |
| hi_o | output | 3 | High-side gate commands, bit 0 = phase A |
| lo_o | output | 3 | Low-side gate commands, bit 0 = phase A |

## Verification
The checker tests, on every cycle, the properties that hold for any input: the brake pattern follows a synchronized brake request, a disabled bridge goes dark, and the pairing and no-shoot-through rules hold. It also checks that the two codes forbidden by the 120° family blank the bridge. Only the bench scenarios can show the exact phase pair that each code produces under each spacing and direction, the mirrored tables, and the three-edge latency. The bench sweeps every spacing, direction and sensor code for this purpose.

// File: rtl/hall_pkg.sv
package hall_pkg;

   localparam int unsigned NUM_PHASES = 3;
   localparam int unsigned NUM_STEPS  = 2 * NUM_PHASES;
   localparam int unsigned STEP_W     = $clog2(NUM_STEPS);

   typedef enum logic [1:0] {
      SPC_60  = 2'b00,
      SPC_240 = 2'b01,
      SPC_120 = 2'b10,
      SPC_300 = 2'b11
   } spacing_e;

   typedef struct packed {
      logic              valid;
      logic [STEP_W-1:0] step;
   } step_t;

   typedef struct packed {
      logic [NUM_PHASES-1:0] hi;
      logic [NUM_PHASES-1:0] lo;
   } gate_t;

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hall_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hall_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q[s] <= '0;
            end else if (s == 0) begin
               stage_q[s] <= d_i;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hall_step_decode.sv
module hall_step_decode
   import hall_pkg::*;
(
   input  logic [NUM_PHASES-1:0] code_i,
   input  spacing_e              spacing_i,
   output step_t                 step_o
);

   logic                  mirror;
   logic                  wide_family;
   logic [NUM_PHASES-1:0] norm;

   assign mirror      = spacing_i[0];
   assign wide_family = spacing_i[0] ^ spacing_i[1];

   always_comb begin
      for (int b = 0; b < NUM_PHASES; b++) begin
         norm[b] = mirror ? code_i[NUM_PHASES-1-b] : code_i[b];
      end
   end

   always_comb begin
      step_o = '0;
      if (wide_family) begin
         unique case (norm)
            3'b001:  step_o = '{valid: 1'b1, step: 3'd0};
            3'b011:  step_o = '{valid: 1'b1, step: 3'd1};
            3'b010:  step_o = '{valid: 1'b1, step: 3'd2};
            3'b110:  step_o = '{valid: 1'b1, step: 3'd3};
            3'b100:  step_o = '{valid: 1'b1, step: 3'd4};
            3'b101:  step_o = '{valid: 1'b1, step: 3'd5};
            default: step_o = '0;
         endcase
      end else begin
         unique case (norm)
            3'b000:  step_o = '{valid: 1'b1, step: 3'd0};
            3'b001:  step_o = '{valid: 1'b1, step: 3'd1};
            3'b011:  step_o = '{valid: 1'b1, step: 3'd2};
            3'b111:  step_o = '{valid: 1'b1, step: 3'd3};
            3'b110:  step_o = '{valid: 1'b1, step: 3'd4};
            3'b100:  step_o = '{valid: 1'b1, step: 3'd5};
            default: step_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/hall_gate_map.sv
module hall_gate_map
   import hall_pkg::*;
(
   input  step_t step_i,
   input  logic  reverse_i,
   input  logic  enable_i,
   input  logic  brake_i,
   output gate_t gate_o
);

   localparam int unsigned HALF = NUM_STEPS / 2;

   logic [STEP_W-1:0] eff_step;
   logic [STEP_W-1:0] hi_idx;
   logic [STEP_W-1:0] lo_sum;
   logic [STEP_W-1:0] lo_idx;
   logic              drive;

   always_comb begin
      if (!reverse_i) begin
         eff_step = step_i.step;
      end else if (step_i.step >= STEP_W'(HALF)) begin
         eff_step = step_i.step - STEP_W'(HALF);
      end else begin
         eff_step = step_i.step + STEP_W'(HALF);
      end
      hi_idx = eff_step >> 1;
      lo_sum = hi_idx + STEP_W'(1) + STEP_W'(eff_step[0]);
      lo_idx = (lo_sum >= STEP_W'(NUM_PHASES)) ? lo_sum - STEP_W'(NUM_PHASES) : lo_sum;
   end

   assign drive = enable_i && step_i.valid;

   generate
      for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
         always_comb begin
            if (brake_i) begin
               gate_o.hi[p] = 1'b0;
               gate_o.lo[p] = 1'b1;
            end else begin
               gate_o.hi[p] = drive && (hi_idx == STEP_W'(p));
               gate_o.lo[p] = drive && (lo_idx == STEP_W'(p));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
   import hall_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] hall_i,
   input  logic [1:0] spacing_i,
   input  logic       dir_i,
   input  logic       enable_i,
   input  logic       brake_i,
   output logic [2:0] hi_o,
   output logic [2:0] lo_o
);

   localparam int unsigned BUS_W = NUM_PHASES + 2 + 3;

   generate
      if (NUM_PHASES != 3) begin : g_bad_phases
         $error("hall_commutator: only three phases are supported");
      end
   endgenerate

   logic [BUS_W-1:0]      raw_bus;
   logic [BUS_W-1:0]      sync_bus;
   logic [NUM_PHASES-1:0] code_s;
   logic [1:0]            sel_s;
   logic                  dir_s;
   logic                  en_s;
   logic                  brk_s;
   step_t                 step;
   gate_t                 gate_d;
   gate_t                 gate_q;

   assign raw_bus = {brake_i, enable_i, dir_i, spacing_i, hall_i};

   hall_sync #(
      .WIDTH  (BUS_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_bus),
      .q_o    (sync_bus)
   );

   assign {brk_s, en_s, dir_s, sel_s, code_s} = sync_bus;

   hall_step_decode u_decode (
      .code_i    (code_s),
      .spacing_i (spacing_e'(sel_s)),
      .step_o    (step)
   );

   hall_gate_map u_map (
      .step_i    (step),
      .reverse_i (dir_s),
      .enable_i  (en_s),
      .brake_i   (brk_s),
      .gate_o    (gate_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gate_q <= '0;
      end else begin
         gate_q <= gate_d;
      end
   end

   assign hi_o = gate_q.hi;
   assign lo_o = gate_q.lo;

endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       brk_s,
   input logic       en_s,
   input logic [1:0] sel_s,
   input logic [2:0] code_s,
   input logic [2:0] hi_o,
   input logic [2:0] lo_o
);

   assert_brake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_s |=> (hi_o == 3'b000 && lo_o == 3'b111));

   assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_s && !en_s) |=> (hi_o == 3'b000 && lo_o == 3'b000));

   assert_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_s && (sel_s[0] ^ sel_s[1]) && (code_s == 3'b000 || code_s == 3'b111))
      |=> (hi_o == 3'b000 && lo_o == 3'b000));

   assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_o != 3'b000) |-> ($countones(hi_o) == 1 && $countones(lo_o) == 1
                            && (hi_o & lo_o) == 3'b000));

   assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_o & lo_o) == 3'b000);

   assert_lo_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_o != 3'b111) |-> $onehot0(lo_o));

endmodule

bind hall_commutator hall_commutator_chk u_chk (
   .clk    (clk_i),
   .rst_n  (rst_ni),
   .brk_s  (brk_s),
   .en_s   (en_s),
   .sel_s  (sel_s),
   .code_s (code_s),
   .hi_o   (hi_o),
   .lo_o   (lo_o)
);

// File: tb/tb_hall_commutator.sv
`timescale 1ns/1ps
module tb_hall_commutator;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall = 3'b000;
   logic [1:0] spacing = 2'b00;
   logic       dir = 1'b0;
   logic       enable = 1'b0;
   logic       brake = 1'b0;
   logic [2:0] hi;
   logic [2:0] lo;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hall_commutator dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .hall_i    (hall),
      .spacing_i (spacing),
      .dir_i     (dir),
      .enable_i  (enable),
      .brake_i   (brake),
      .hi_o      (hi),
      .lo_o      (lo)
   );

   function automatic logic [2:0] code_of(input bit wide, input int k);
      logic [2:0] c;
      for (int b = 0; b < 3; b++) begin
         if (wide) begin
            int d = ((k - 2*b) % 6 + 6) % 6;
            c[b] = (d == 5 || d == 0 || d == 1);
         end else begin
            c[b] = (k > b) && (k <= b + 3);
         end
      end
      return c;
   endfunction

   function automatic logic [5:0] expect_gate(input logic [1:0] sp, input logic rv,
                                              input logic en, input logic bk,
                                              input logic [2:0] h);
      logic [2:0] n;
      bit wide;
      int step = -1;
      int k;
      int hp;
      int lp;
      logic [2:0] eh = 3'b000;
      logic [2:0] el = 3'b000;
      if (bk) return {3'b000, 3'b111};
      if (!en) return 6'b0;
      n = sp[0] ? {h[0], h[1], h[2]} : h;
      wide = sp[0] ^ sp[1];
      for (int i = 0; i < 6; i++) if (code_of(wide, i) == n) step = i;
      if (step < 0) return 6'b0;
      k = rv ? (step + 3) % 6 : step;
      hp = k / 2;
      lp = (hp + 1 + k % 2) % 3;
      eh[hp] = 1'b1;
      el[lp] = 1'b1;
      return {eh, el};
   endfunction

   task automatic check(input string req, input logic [5:0] exp);
      checks++;
      if ({hi, lo} !== exp) begin
         errors++;
         $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
                  req, hi, lo, exp[5:3], exp[2:0]);
      end
   endtask

   task automatic apply(input logic [1:0] sp, input logic rv, input logic en,
                        input logic bk, input logic [2:0] h);
      @(negedge clk);
      spacing = sp; dir = rv; enable = en; brake = bk; hall = h;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      enable = 1'b1; hall = 3'b001; spacing = 2'b10; brake = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset", 6'b0);
      rst_n = 1'b1;

      // R1 R2 R3 R4: full sweep of spacing, direction and sensor code
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 2; d++)
            for (int c = 0; c < 8; c++) begin
               apply(2'(s), 1'(d), 1'b1, 1'b0, 3'(c));
               check(d ? "R1 R2 R4 sweep" : "R1 R2 R3 sweep",
                     expect_gate(2'(s), 1'(d), 1'b1, 1'b0, 3'(c)));
            end

      // R5: brake wins over every other input
      for (int c = 0; c < 8; c++) begin
         apply(2'(c % 4), 1'(c / 4), 1'(c % 2), 1'b1, 3'(c));
         check("R5 brake", {3'b000, 3'b111});
      end

      // R6: disabled bridge stays off for every code
      for (int c = 0; c < 8; c++) begin
         apply(2'b10, 1'b0, 1'b0, 1'b0, 3'(c));
         check("R6 disable", 6'b0);
      end

      // R8: latency of three rising edges
      apply(2'b10, 1'b0, 1'b1, 1'b0, 3'b001);
      check("R8 setup", expect_gate(2'b10, 1'b0, 1'b1, 1'b0, 3'b001));
      @(negedge clk);
      hall = 3'b011;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R8 before", expect_gate(2'b10, 1'b0, 1'b1, 1'b0, 3'b001));
      @(posedge clk);
      @(negedge clk);
      check("R8 after", expect_gate(2'b10, 1'b0, 1'b1, 1'b0, 3'b011));

      // R7 R9: a forward rotation at 60 degrees walks all six pairs
      for (int k = 0; k < 6; k++) begin
         apply(2'b00, 1'b0, 1'b1, 1'b0, code_of(1'b0, k));
         check("R7 R9 rotation", expect_gate(2'b00, 1'b0, 1'b1, 1'b0, code_of(1'b0, k)));
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule